// File: doc/BRIEF.md
# Bus-Mapped Synchronous RAM Window

This block is an AXI4-Lite slave that exposes an external single-port synchronous RAM as a range of bus addresses. Each accepted bus write becomes one RAM write cycle. Each accepted bus read becomes one RAM read-enable pulse, and the block captures the RAM output a fixed, parameter-set number of cycles later. It then holds that word on the read-data channel until the master takes it.

A parameter selects one of three access modes:

| MODE | Name | Behaviour |
|---|---|---|
| 0 | store-only | The block drives writes only. Bus reads are refused. |
| 1 | store-and-fetch | Both bus writes and bus reads reach the RAM. |
| 2 | fetch-only | The block drives reads only. Bus writes are refused. |

A refused access completes on the bus with an error response and leaves the RAM pins idle. Writes and reads share the one RAM port. A write that arrives in the same cycle as a read takes the port first.

Top module: `axil_ram_window`

## Requirements
- R1: After reset is released, `s_bvalid`, `s_rvalid`, `ram_wen` and `ram_ren` are all low.
- R2: Write acceptance works as follows:
  - A write is accepted in a cycle where `s_awvalid` and `s_wvalid` are both high and no write response is pending. In that cycle `s_awready` and `s_wready` are both high.
  - When MODE is not 2, `ram_wen` is high for exactly that cycle, with `ram_wdata` equal to `s_wdata`.
  - In the next cycle `s_bvalid` rises with `s_bresp` = 2'b00, except as R8 states.
- R3: `ram_addr` equals the bus byte address shifted right by 2. The two lowest address bits have no effect.
- R4: Each accepted read with MODE not 0 produces exactly one single-cycle `ram_ren` pulse. The pulse falls in the acceptance cycle, with `ram_addr` showing the read word.
- R5: The RAM output is captured exactly RD_LAT cycles after the `ram_ren` cycle, with RD_LAT between 1 and 5. `s_rvalid` rises RD_LAT+1 cycles after the read-address handshake edge, with `s_rresp` = 2'b00.
- R6: While `s_rready` is low, `s_rvalid`, `s_rdata` and `s_rresp` hold their values. While `s_bready` is low, `s_bvalid` and `s_bresp` hold their values.
- R7: Only one read can be outstanding at a time. `s_arready` stays low from the handshake until the read-data handshake has completed, and no `ram_ren` is issued in that interval.
- R8: Refused accesses complete with an error and do not touch the RAM:
  - In MODE 2, a write completes with `s_bresp` = 2'b10 (error) and no `ram_wen`.
  - In MODE 0, a read completes one cycle after its handshake with `s_rresp` = 2'b10, `s_rdata` = 0 and no `ram_ren`.
- R9: When a write and a read are both presented in the same cycle, the write is accepted that cycle and `s_arready` stays low. The read is accepted in a later cycle, so a read of the same word returns the newly written data.
- R10: `ram_wen` and `ram_ren` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | RAM_AW+2 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | RAM_AW+2 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wen | output | 1 | RAM write enable |
| ram_wdata | output | DATA_W | RAM write data |
| ram_ren | output | 1 | RAM read enable |
| ram_rdata | input | DATA_W | RAM read data |

## Verification
The hardest case to reach from the ports is a write and a read arriving together and contending for the single RAM port. The stimulus raises the write-address, write-data and read-address valids on the same clock edge, with the read aimed at the word being written. It then confirms that the read stalls for that cycle and returns the new data. Capture timing is exercised at both latency extremes, 1 and 5. The bench RAM model drives a poison word on its output in every cycle except the one valid cycle, so a capture that is one cycle early or late returns that poison value.

// File: rtl/axrw_pkg.sv
// Package: shared constants for the RAM window.
// Holds the mode codes and the bus response codes used by every module.
package axrw_pkg;
    localparam int MODE_STORE = 0;   // writes only
    localparam int MODE_BOTH  = 1;   // writes and reads
    localparam int MODE_FETCH = 2;   // reads only

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } resp_e;
endpackage

// File: rtl/axrw_lat_pipe.sv
// Module: axrw_lat_pipe
// Delays a one-bit token by DEPTH clock cycles with a chain of flops.
// Assumes DEPTH >= 1. Its output marks the cycle in which RAM read data is valid.
module axrw_lat_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_in,
    output logic tok_out
);
    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            // Purpose: a single stage of delay.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= tok_in;
            end
        end else begin : g_chain
            // Purpose: shift the token one stage along each cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[DEPTH-2:0], tok_in};
            end
        end
    endgenerate

    assign tok_out = stage_q[DEPTH-1];
endmodule

// File: rtl/axrw_wr_ctrl.sv
// Module: axrw_wr_ctrl
// Accepts the write address and write data together and issues one RAM write.
// Then holds the write response until the master takes it.
// Assumes the write always has priority on the RAM port.
// In fetch-only mode it refuses the write with an error and leaves the RAM alone.
module axrw_wr_ctrl
    import axrw_pkg::*;
#(
    parameter int RAM_AW = 6,
    parameter int DATA_W = 32,
    parameter int MODE   = MODE_BOTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [RAM_AW+1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    output logic              wr_fire,
    output logic [RAM_AW-1:0] wr_word,
    output logic [DATA_W-1:0] wr_data
);
    localparam bit CAN_WRITE = (MODE != MODE_FETCH);

    logic  take;
    logic  bvalid_q;
    resp_e bresp_q;

    // Purpose: accept both write channels in the same cycle when no response is pending.
    always_comb begin
        take = awvalid && wvalid && !bvalid_q;
    end

    assign awready = take;
    assign wready  = take;
    assign wr_fire = take && CAN_WRITE;
    assign wr_word = awaddr[RAM_AW+1:2];
    assign wr_data = CAN_WRITE ? wdata : '0;

    // Purpose: raise the response after acceptance and hold it until bready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid_q <= 1'b0;
            bresp_q  <= RESP_OKAY;
        end else if (take) begin
            bvalid_q <= 1'b1;
            bresp_q  <= CAN_WRITE ? RESP_OKAY : RESP_SLVERR;
        end else if (bvalid_q && bready) begin
            bvalid_q <= 1'b0;
        end
    end

    assign bvalid = bvalid_q;
    assign bresp  = bresp_q;
endmodule

// File: rtl/axrw_rd_ctrl.sv
// Module: axrw_rd_ctrl
// Accepts one read at a time and pulses the RAM read enable for one cycle.
// Captures RAM data RD_LAT cycles later and holds it until rready.
// Assumes the RAM returns data exactly RD_LAT cycles after its enable.
// In store-only mode it answers every read with an error and zero data.
module axrw_rd_ctrl
    import axrw_pkg::*;
#(
    parameter int RAM_AW = 6,
    parameter int DATA_W = 32,
    parameter int MODE   = MODE_BOTH,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [RAM_AW+1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    input  logic              port_taken,
    output logic              rd_fire,
    output logic [RAM_AW-1:0] rd_word,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam bit CAN_READ = (MODE != MODE_STORE);

    logic              busy_q;
    logic              accept;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    resp_e             rresp_q;
    logic              capture;

    // Purpose: accept a read when idle and, for RAM reads, when the port is free.
    always_comb begin
        accept = arvalid && !busy_q && (!CAN_READ || !port_taken);
    end

    assign arready = accept;
    assign rd_fire = accept && CAN_READ;
    assign rd_word = araddr[RAM_AW+1:2];

    generate
        if (CAN_READ) begin : g_pipe
            axrw_lat_pipe #(.DEPTH(RD_LAT)) u_pipe (
                .clk     (clk),
                .rst_n   (rst_n),
                .tok_in  (rd_fire),
                .tok_out (capture)
            );
        end else begin : g_nopipe
            assign capture = 1'b0;
        end
    endgenerate

    // Purpose: mark a read outstanding from acceptance until the data handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)                  busy_q <= 1'b0;
        else if (accept)             busy_q <= 1'b1;
        else if (rvalid_q && rready) busy_q <= 1'b0;
    end

    // Purpose: load the read-data holding register from the RAM or from the error path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
            rresp_q  <= RESP_OKAY;
        end else if (capture) begin
            rvalid_q <= 1'b1;
            rdata_q  <= ram_rdata;
            rresp_q  <= RESP_OKAY;
        end else if (accept && !CAN_READ) begin
            rvalid_q <= 1'b1;
            rdata_q  <= '0;
            rresp_q  <= RESP_SLVERR;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;
    assign rresp  = rresp_q;
endmodule

// File: rtl/axil_ram_window.sv
// Module: axil_ram_window
// AXI4-Lite slave window onto one external single-port synchronous RAM.
// Writes take the RAM port ahead of reads in the same cycle.
// Assumes the RAM samples address, enables and data on the rising clock edge.
// Assumes RD_LAT lies in 1..5 and MODE is one of the axrw_pkg mode codes.
module axil_ram_window
    import axrw_pkg::*;
#(
    parameter int RAM_AW = 6,
    parameter int DATA_W = 32,
    parameter int MODE   = MODE_BOTH,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [RAM_AW+1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [RAM_AW+1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_wen,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_ren,
    input  logic [DATA_W-1:0] ram_rdata
);
    logic              wr_fire;
    logic [RAM_AW-1:0] wr_word;
    logic [DATA_W-1:0] wr_data;
    logic              rd_fire;
    logic [RAM_AW-1:0] rd_word;

    axrw_wr_ctrl #(.RAM_AW(RAM_AW), .DATA_W(DATA_W), .MODE(MODE)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .awaddr  (s_awaddr),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .wdata   (s_wdata),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .bresp   (s_bresp),
        .wr_fire (wr_fire),
        .wr_word (wr_word),
        .wr_data (wr_data)
    );

    axrw_rd_ctrl #(.RAM_AW(RAM_AW), .DATA_W(DATA_W), .MODE(MODE), .RD_LAT(RD_LAT)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .arvalid    (s_arvalid),
        .arready    (s_arready),
        .araddr     (s_araddr),
        .rvalid     (s_rvalid),
        .rready     (s_rready),
        .rdata      (s_rdata),
        .rresp      (s_rresp),
        .port_taken (wr_fire),
        .rd_fire    (rd_fire),
        .rd_word    (rd_word),
        .ram_rdata  (ram_rdata)
    );

    // Purpose: steer the shared RAM address to the writer or the reader.
    always_comb begin
        ram_addr = wr_fire ? wr_word : rd_word;
    end

    assign ram_wen   = wr_fire;
    assign ram_wdata = wr_data;
    assign ram_ren   = rd_fire;
endmodule

// File: rtl/axil_ram_window_chk.sv
// Module: axil_ram_window_chk
// Protocol and timing checker, bound to every axil_ram_window instance.
// Observes the top-level ports only.
module axil_ram_window_chk
    import axrw_pkg::*;
#(
    parameter int RAM_AW = 6,
    parameter int DATA_W = 32,
    parameter int MODE   = MODE_BOTH,
    parameter int RD_LAT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_awvalid,
    input logic              s_awready,
    input logic              s_wvalid,
    input logic              s_wready,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [1:0]        s_bresp,
    input logic              s_arvalid,
    input logic              s_arready,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [DATA_W-1:0] s_rdata,
    input logic [1:0]        s_rresp,
    input logic              ram_wen,
    input logic              ram_ren
);
    p_port_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_wen && ram_ren));
    p_wen_on_shake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wen |-> (s_awvalid && s_awready && s_wvalid && s_wready));
    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && s_awready) |=> s_bvalid);
    p_ren_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ren |=> !ram_ren);
    p_capture_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE != MODE_STORE && $rose(s_rvalid)) |-> $past(ram_ren, RD_LAT + 1));
    p_rhold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));
    p_bhold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));
    p_single_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_arready);
    p_fetch_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_FETCH && s_bvalid) |-> (s_bresp == 2'b10));
    p_store_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_STORE && s_rvalid) |-> (s_rresp == 2'b10 && s_rdata == '0));
    p_write_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_BOTH && s_awvalid && s_wvalid && !s_bvalid) |-> !ram_ren);
endmodule

bind axil_ram_window axil_ram_window_chk #(
    .RAM_AW(RAM_AW), .DATA_W(DATA_W), .MODE(MODE), .RD_LAT(RD_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .ram_wen(ram_wen), .ram_ren(ram_ren)
);

// File: tb/sim_axil_ram_window.sv
// Bench RAM: a synchronous RAM with LAT cycles of read latency.
// The output shows a poison word in every cycle except the one where the data is valid.
module sim_ram_model #(
    parameter int AW   = 6,
    parameter int DW   = 32,
    parameter int LAT  = 2,
    parameter int SEED = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    input  logic          ren,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [1<<AW];
    logic [DW-1:0] dat [LAT];
    logic [LAT-1:0] vld;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= DW'((SEED << 16) | i);
            vld <= '0;
        end else begin
            if (wen) mem[addr] <= wdata;
            vld[0] <= ren;
            dat[0] <= mem[addr];
            for (int s = 1; s < LAT; s++) begin
                vld[s] <= vld[s-1];
                dat[s] <= dat[s-1];
            end
        end
    end

    assign rdata = vld[LAT-1] ? dat[LAT-1] : 32'hBADD_0BAD;
endmodule

module sim_axil_ram_window;
    localparam int AW = 6;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int sel = 0;
    logic awvalid = 0, wvalid = 0, arvalid = 0, bready = 0, rready = 0;
    logic [AW+1:0] awaddr = '0, araddr = '0;
    logic [DW-1:0] wdata = '0;

    logic awready_o [3];
    logic wready_o [3];
    logic bvalid_o [3];
    logic [1:0] bresp_o [3];
    logic arready_o [3];
    logic rvalid_o [3];
    logic [DW-1:0] rdata_o [3];
    logic [1:0] rresp_o [3];
    logic [AW-1:0] maddr [3];
    logic mwen [3];
    logic mren [3];
    logic [DW-1:0] mwdata [3];
    logic [DW-1:0] mrdata [3];

    int wen_cnt [3];
    int ren_cnt [3];
    logic [AW-1:0] last_waddr [3];
    logic [DW-1:0] last_wdata [3];
    logic [AW-1:0] last_raddr [3];

    int n_checks = 0;
    int n_errors = 0;

    // u0: store-and-fetch mode, latency 5.
    axil_ram_window #(.RAM_AW(AW), .DATA_W(DW), .MODE(1), .RD_LAT(5)) u0 (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(awvalid && sel == 0), .s_awready(awready_o[0]), .s_awaddr(awaddr),
        .s_wvalid(wvalid && sel == 0), .s_wready(wready_o[0]), .s_wdata(wdata),
        .s_bvalid(bvalid_o[0]), .s_bready(bready && sel == 0), .s_bresp(bresp_o[0]),
        .s_arvalid(arvalid && sel == 0), .s_arready(arready_o[0]), .s_araddr(araddr),
        .s_rvalid(rvalid_o[0]), .s_rready(rready && sel == 0), .s_rdata(rdata_o[0]),
        .s_rresp(rresp_o[0]),
        .ram_addr(maddr[0]), .ram_wen(mwen[0]), .ram_wdata(mwdata[0]),
        .ram_ren(mren[0]), .ram_rdata(mrdata[0]));
    sim_ram_model #(.AW(AW), .DW(DW), .LAT(5), .SEED(16'h00A0)) r0 (
        .clk(clk), .rst_n(rst_n), .addr(maddr[0]), .wen(mwen[0]),
        .wdata(mwdata[0]), .ren(mren[0]), .rdata(mrdata[0]));

    // u1: fetch-only mode, latency 1.
    axil_ram_window #(.RAM_AW(AW), .DATA_W(DW), .MODE(2), .RD_LAT(1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(awvalid && sel == 1), .s_awready(awready_o[1]), .s_awaddr(awaddr),
        .s_wvalid(wvalid && sel == 1), .s_wready(wready_o[1]), .s_wdata(wdata),
        .s_bvalid(bvalid_o[1]), .s_bready(bready && sel == 1), .s_bresp(bresp_o[1]),
        .s_arvalid(arvalid && sel == 1), .s_arready(arready_o[1]), .s_araddr(araddr),
        .s_rvalid(rvalid_o[1]), .s_rready(rready && sel == 1), .s_rdata(rdata_o[1]),
        .s_rresp(rresp_o[1]),
        .ram_addr(maddr[1]), .ram_wen(mwen[1]), .ram_wdata(mwdata[1]),
        .ram_ren(mren[1]), .ram_rdata(mrdata[1]));
    sim_ram_model #(.AW(AW), .DW(DW), .LAT(1), .SEED(16'h00B1)) r1 (
        .clk(clk), .rst_n(rst_n), .addr(maddr[1]), .wen(mwen[1]),
        .wdata(mwdata[1]), .ren(mren[1]), .rdata(mrdata[1]));

    // u2: store-only mode, latency 2.
    axil_ram_window #(.RAM_AW(AW), .DATA_W(DW), .MODE(0), .RD_LAT(2)) u2 (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(awvalid && sel == 2), .s_awready(awready_o[2]), .s_awaddr(awaddr),
        .s_wvalid(wvalid && sel == 2), .s_wready(wready_o[2]), .s_wdata(wdata),
        .s_bvalid(bvalid_o[2]), .s_bready(bready && sel == 2), .s_bresp(bresp_o[2]),
        .s_arvalid(arvalid && sel == 2), .s_arready(arready_o[2]), .s_araddr(araddr),
        .s_rvalid(rvalid_o[2]), .s_rready(rready && sel == 2), .s_rdata(rdata_o[2]),
        .s_rresp(rresp_o[2]),
        .ram_addr(maddr[2]), .ram_wen(mwen[2]), .ram_wdata(mwdata[2]),
        .ram_ren(mren[2]), .ram_rdata(mrdata[2]));
    sim_ram_model #(.AW(AW), .DW(DW), .LAT(2), .SEED(16'h00C2)) r2 (
        .clk(clk), .rst_n(rst_n), .addr(maddr[2]), .wen(mwen[2]),
        .wdata(mwdata[2]), .ren(mren[2]), .rdata(mrdata[2]));

    // RAM pin monitor. Inputs change just after the rising edge, so sampling is on the falling edge.
    always @(negedge clk) begin
        for (int k = 0; k < 3; k++) begin
            if (!rst_n) begin
                wen_cnt[k] = 0;
                ren_cnt[k] = 0;
            end else begin
                if (mwen[k]) begin
                    wen_cnt[k]++;
                    last_waddr[k] = maddr[k];
                    last_wdata[k] = mwdata[k];
                end
                if (mren[k]) begin
                    ren_cnt[k]++;
                    last_raddr[k] = maddr[k];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // One write: the handshake, the RAM pins, then the response and its hold.
    task automatic do_write(input int k, input logic [AW+1:0] a, input logic [DW-1:0] d,
                            input logic [1:0] er, input int exp_wen, input string tag);
        int w0 = wen_cnt[k];
        @(posedge clk); #1;
        sel = k; awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
        @(negedge clk);
        chk(awready_o[k] && wready_o[k], {tag, " R2 ready together"}, 32'(awready_o[k]), 1);
        @(posedge clk); #1;
        awvalid = 0; wvalid = 0;
        @(negedge clk);
        chk(bvalid_o[k] && bresp_o[k] == er, {tag, " R2/R8 bresp"}, 32'(bresp_o[k]), 32'(er));
        chk(wen_cnt[k] - w0 == exp_wen, {tag, " R2/R8 wen count"}, 32'(wen_cnt[k] - w0), 32'(exp_wen));
        if (exp_wen == 1) begin
            chk(last_waddr[k] == a[AW+1:2], {tag, " R3 write word"}, 32'(last_waddr[k]), 32'(a[AW+1:2]));
            chk(last_wdata[k] == d, {tag, " R2 write data"}, last_wdata[k], d);
        end
        repeat (2) @(negedge clk);
        chk(bvalid_o[k] && bresp_o[k] == er, {tag, " R6 b held"}, 32'(bvalid_o[k]), 1);
        @(posedge clk); #1; bready = 1;
        @(posedge clk); #1; bready = 0;
        @(negedge clk);
        chk(!bvalid_o[k], {tag, " R6 b released"}, 32'(bvalid_o[k]), 0);
    endtask

    // Waits for rvalid and checks the latency and the data. Afterwards the response is still outstanding.
    task automatic await_read(input int k, input logic [DW-1:0] ed, input logic [1:0] er,
                              input int exp_n, input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rvalid_o[k] && n < 20);
        chk(n == exp_n, {tag, " R5/R8 cycles to rvalid"}, 32'(n), 32'(exp_n));
        chk(rdata_o[k] == ed, {tag, " R5 rdata"}, rdata_o[k], ed);
        chk(rresp_o[k] == er, {tag, " R5/R8 rresp"}, 32'(rresp_o[k]), 32'(er));
    endtask

    task automatic release_read(input int k, input string tag);
        @(posedge clk); #1; rready = 1;
        @(posedge clk); #1; rready = 0;
        @(negedge clk);
        chk(!rvalid_o[k], {tag, " R6 r released"}, 32'(rvalid_o[k]), 0);
    endtask

    // One read: the handshake, the latency, the data, a hold, the enable count.
    task automatic do_read(input int k, input logic [AW+1:0] a, input logic [DW-1:0] ed,
                           input logic [1:0] er, input int exp_n, input int exp_ren, input string tag);
        int r0 = ren_cnt[k];
        logic [DW-1:0] held;
        @(posedge clk); #1;
        sel = k; araddr = a; arvalid = 1;
        @(negedge clk);
        chk(arready_o[k], {tag, " R4 arready idle"}, 32'(arready_o[k]), 1);
        @(posedge clk); #1; arvalid = 0;
        await_read(k, ed, er, exp_n, tag);
        chk(ren_cnt[k] - r0 == exp_ren, {tag, " R4/R8 ren count"}, 32'(ren_cnt[k] - r0), 32'(exp_ren));
        if (exp_ren == 1)
            chk(last_raddr[k] == a[AW+1:2], {tag, " R3 read word"}, 32'(last_raddr[k]), 32'(a[AW+1:2]));
        held = rdata_o[k];
        repeat (3) @(negedge clk);
        chk(rvalid_o[k] && rdata_o[k] == held, {tag, " R6 r held"}, rdata_o[k], held);
        release_read(k, tag);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++)
            chk(!bvalid_o[k] && !rvalid_o[k] && !mwen[k] && !mren[k], "R1 idle after reset",
                {bvalid_o[k], rvalid_o[k], mwen[k], mren[k]}, 0);
    endtask

    task automatic t_both_mode();
        do_read(0, 8'h10, 32'h00A0_0004, 2'b00, 6, 1, "u0 init R5");
        do_write(0, 8'h24, 32'h1234_5678, 2'b00, 1, "u0 write R2");
        do_read(0, 8'h27, 32'h1234_5678, 2'b00, 6, 1, "u0 readback R3");
    endtask

    task automatic t_fetch_mode();
        do_read(1, 8'h08, 32'h00B1_0002, 2'b00, 2, 1, "u1 read R5");
        do_write(1, 8'h08, 32'hFFFF_0000, 2'b10, 0, "u1 refused R8");
        do_read(1, 8'h08, 32'h00B1_0002, 2'b00, 2, 1, "u1 unchanged R8");
    endtask

    task automatic t_store_mode();
        do_write(2, 8'h3C, 32'hCAFE_F00D, 2'b00, 1, "u2 write R2");
        do_read(2, 8'h3C, 32'h0, 2'b10, 1, 0, "u2 refused R8");
    endtask

    task automatic t_one_outstanding();
        int r0;
        @(posedge clk); #1; sel = 0; araddr = 8'h04; arvalid = 1;
        @(posedge clk); #1; araddr = 8'h08;
        r0 = ren_cnt[0];
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            chk(!arready_o[0], "R7 arready low while outstanding", 32'(arready_o[0]), 0);
        end
        chk(ren_cnt[0] == r0, "R7 no enable while outstanding", 32'(ren_cnt[0] - r0), 0);
        chk(rvalid_o[0] && rdata_o[0] == 32'h00A0_0001, "R7 first read data", rdata_o[0], 32'h00A0_0001);
        @(posedge clk); #1; rready = 1;
        @(posedge clk); #1; rready = 0;
        @(negedge clk);
        chk(arready_o[0], "R7 next read accepted after release", 32'(arready_o[0]), 1);
        @(posedge clk); #1; arvalid = 0;
        await_read(0, 32'h00A0_0002, 2'b00, 6, "R7 second read");
        release_read(0, "R7 second read");
    endtask

    task automatic t_collision();
        @(posedge clk); #1;
        sel = 0; awaddr = 8'h30; araddr = 8'h30; wdata = 32'h5A5A_A5A5;
        awvalid = 1; wvalid = 1; arvalid = 1;
        @(negedge clk);
        chk(awready_o[0] && !arready_o[0], "R9 write wins the port", {arready_o[0], awready_o[0]}, 1);
        chk(mwen[0] && !mren[0], "R10 one enable only", {mwen[0], mren[0]}, 2);
        @(posedge clk); #1; awvalid = 0; wvalid = 0;
        @(negedge clk);
        chk(arready_o[0], "R9 read follows", 32'(arready_o[0]), 1);
        @(posedge clk); #1; arvalid = 0; bready = 1;
        await_read(0, 32'h5A5A_A5A5, 2'b00, 6, "R9 same word");
        bready = 0;
        release_read(0, "R9 same word");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_both_mode();
        t_fetch_mode();
        t_store_mode();
        t_one_outstanding();
        t_collision();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule